// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter

This unit shifts one integer element of a SIMD datapath by a signed amount. The sign of the count chooses the direction: a non-negative count shifts left and a negative count shifts right by its magnitude. Right shifts can round half-up. Left shifts can detect overflow and clamp the result.

The element width is 8, 16, 32 or 64 bits, picked per operation. Three modes are available: signed, unsigned, and a signed-input mode whose result is unsigned. The result goes out on a 64-bit bus, extended from the element width. A sticky flag records every clamping event until it is cleared.

Operands are sampled on a clock edge while `inValid` is high. The result comes out one cycle later, with a single-cycle `outValid` pulse. Lane splitting, predication and decode belong to the surrounding datapath.

Top module: `sat_round_shifter`

## Requirements
- R1: `inShift` is an 8-bit two's complement count: negative shifts right by its magnitude, zero or positive shifts left. Size codes 0, 1, 2 and 3 select element widths of 8, 16, 32 and 64 bits. Mode codes are 0 signed, 1 unsigned and 2 signed-to-unsigned; code 3 behaves like code 1. A zero element always gives a zero result.
- R2: With `inRound` high, a right shift rounds half-up: the result is floor((x + 2^(n-1)) / 2^n) for a shift of n.
- R3: In signed mode, a right shift of at least the element width gives 0 when rounding is on, and all copies of the sign bit when rounding is off.
- R4: In the unsigned modes, a right shift whose magnitude is at least the width plus the round bit (1 when rounding, else 0) gives 0.
- R5: In signed mode with `inSat` high, a left shift whose true result does not fit the element gives the most positive value for a non-negative input and the most negative value for a negative input.
- R6: In the unsigned modes with `inSat` high, a left shift whose true result exceeds the element's range gives all ones in the element.
- R7: A left shift of at least the element width gives 0 when the element is zero or `inSat` is low. Otherwise it clamps as in R5 and R6.
- R8: In signed-to-unsigned mode with `inSat` high, an element whose top bit is set gives 0 and counts as a clamping event.
- R9: With `inSat` low, an overflowing left shift returns the truncated, wrapped element and never counts as a clamping event.
- R10: `satFlag` rises with the result of any clamping operation and stays high until `satClear` is sampled high. If a clear and an event share a cycle, the flag ends up set.
- R11: Only the low element-width bits of `inData` take part. The result is sign-extended to 64 bits in signed mode and zero-extended in the other modes.
- R12: `outValid` is high for exactly the cycle after each cycle in which `inValid` was sampled high. `outData` holds its value while no operation is accepted. Reset clears `outData`, `outValid` and `satFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand accepted on this edge |
| inData | input | 64 | Element in the low bits |
| inShift | input | 8 | Signed shift count |
| inSize | input | 2 | Element width code |
| inMode | input | 2 | Signedness mode code |
| inRound | input | 1 | Round right shifts |
| inSat | input | 1 | Clamp overflowing left shifts |
| satClear | input | 1 | Clears the sticky flag |
| outValid | output | 1 | Result valid pulse |
| outData | output | 64 | Extended result |
| satFlag | output | 1 | Sticky clamping flag |

## Verification
The unit keeps almost no state: one output register, a valid bit and the sticky flag. A wrong element mask, limit compare or rounding carry therefore shows on `outData` in the very cycle after the operand that exercises it. A wrong flag update shows on `satFlag` in the same cycle. A flag that fails to stick or to clear shows on a later clean operation, when `satFlag` differs from the running expectation. Random counts are concentrated around plus and minus the element width, so the limit compares of R3, R4 and R7 are hit on both sides for every width.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

  typedef enum logic [1:0] {
    MODE_SIGNED   = 2'd0,
    MODE_UNSIGNED = 2'd1,
    MODE_S2U      = 2'd2,
    MODE_ALT_U    = 2'd3
  } shiftMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // register a new result this edge
    logic flagSet;   // this operation raises the sticky flag
  } ctrlStrobes_t;

endpackage

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
  import vsr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         satClear,
  input  logic         satEvent,
  output ctrlStrobes_t strobes,
  output logic         outValid,
  output logic         satFlag
);

  always_comb begin
    strobes.capture = inValid;
    strobes.flagSet = inValid && satEvent;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      satFlag  <= 1'b0;
    end else begin
      outValid <= strobes.capture;
      satFlag  <= (satFlag && !satClear) || strobes.flagSet;
    end
  end

  // R12: one valid pulse per accepted operand
  p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R10: sticky behaviour
  p_flag_sticks_r10: assert property (@(posedge clk) disable iff (!rstN)
    satFlag && !satClear |=> satFlag);
  p_flag_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    satClear && !strobes.flagSet |=> !satFlag);
  p_flag_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagSet |=> satFlag);

endmodule

// File: rtl/vsr_datapath.sv
module vsr_datapath
  import vsr_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHIFT_W = 8,
  parameter int SIZE_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [DATA_W-1:0]  inData,
  input  logic [SHIFT_W-1:0] inShift,
  input  logic [SIZE_W-1:0]  inSize,
  input  shiftMode_e         inMode,
  input  logic               inRound,
  input  logic               inSat,
  output logic               satEvent,
  output logic [DATA_W-1:0]  outData
);

  localparam int EXT_W = 2 * DATA_W;
  localparam int MAG_W = SHIFT_W + 1;

  int unsigned      elemW;
  int unsigned      magInt;
  logic [EXT_W-1:0] widthMask;
  logic [EXT_W-1:0] topBit;
  logic [EXT_W-1:0] srcLow;
  logic [EXT_W-1:0] srcSigned;
  logic [EXT_W-1:0] opnd;
  logic [EXT_W-1:0] tmp;
  logic [EXT_W-1:0] halved;
  logic [EXT_W-1:0] rightVal;
  logic [EXT_W-1:0] prod;
  logic [EXT_W-1:0] hiPart;
  logic [EXT_W-1:0] satVal;
  logic [EXT_W-1:0] rawRes;
  logic [EXT_W-1:0] resMasked;
  logic [EXT_W-1:0] resExt;
  logic [MAG_W-1:0] mag;
  logic             signedMode;
  logic             s2uMode;
  logic             srcNeg;
  logic             srcZero;
  logic             isRight;
  logic             rightBig;
  logic             leftBig;
  logic             leftFits;
  logic             needSat;
  logic             s2uClamp;
  logic [DATA_W-1:0] nextData;

  // element framing
  always_comb begin
    elemW      = 32'd8 << inSize;
    widthMask  = (EXT_W'(1) << elemW) - EXT_W'(1);
    topBit     = widthMask ^ (widthMask >> 1);
    srcLow     = EXT_W'(inData) & widthMask;
    srcNeg     = |(srcLow & topBit);
    srcZero    = (srcLow == '0);
    srcSigned  = srcNeg ? (srcLow | ~widthMask) : srcLow;
    signedMode = (inMode == MODE_SIGNED);
    s2uMode    = (inMode == MODE_S2U);
    opnd       = signedMode ? srcSigned : srcLow;
  end

  // shift count decode
  always_comb begin
    isRight = inShift[SHIFT_W-1];
    if (isRight) mag = MAG_W'(-{inShift[SHIFT_W-1], inShift});
    else         mag = {1'b0, inShift};
    magInt = 32'(mag);
  end

  // right path: shift by n-1, then fold the last discarded bit back in
  always_comb begin
    if (magInt == 0) tmp = opnd;
    else if (signedMode) tmp = EXT_W'($signed(opnd) >>> (magInt - 32'd1));
    else tmp = opnd >> (magInt - 32'd1);
    halved   = signedMode ? EXT_W'($signed(tmp) >>> 1) : (tmp >> 1);
    rightVal = inRound ? (halved + EXT_W'(tmp[0])) : halved;
    if (signedMode) rightBig = (magInt >= elemW);
    else            rightBig = (magInt >= elemW + 32'(inRound));
  end

  // left path: wide product plus range test
  always_comb begin
    prod    = opnd << magInt;
    leftBig = (magInt >= elemW);
    if (signedMode) hiPart = EXT_W'($signed(prod) >>> (elemW - 32'd1));
    else            hiPart = prod >> elemW;
    if (signedMode) leftFits = (hiPart == '0) || (hiPart == '1);
    else            leftFits = (hiPart == '0);
    needSat = inSat && (leftBig ? !srcZero : !leftFits);
    if (signedMode) satVal = srcNeg ? topBit : (widthMask >> 1);
    else            satVal = widthMask;
  end

  // result selection
  always_comb begin
    s2uClamp = s2uMode && inSat && srcNeg;
    satEvent = 1'b0;
    if (s2uClamp) begin
      rawRes   = '0;
      satEvent = 1'b1;
    end else if (isRight) begin
      if (rightBig) rawRes = (signedMode && !inRound && srcNeg) ? '1 : '0;
      else          rawRes = rightVal;
    end else if (needSat) begin
      rawRes   = satVal;
      satEvent = 1'b1;
    end else if (leftBig) begin
      rawRes = '0;
    end else begin
      rawRes = prod;
    end
    resMasked = rawRes & widthMask;
    resExt    = (signedMode && |(resMasked & topBit)) ? (resMasked | ~widthMask) : resMasked;
    nextData  = DATA_W'(resExt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                outData <= '0;
    else if (strobes.capture) outData <= nextData;
  end

  // R1: a zero element never produces a non-zero result
  p_zero_in_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && (inData == '0) |=> outData == '0);
  // R6: unsigned clamping yields all ones in the element
  p_unsigned_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && satEvent && (inMode == MODE_UNSIGNED)
    |=> outData == DATA_W'($past(widthMask)));
  // R9: no clamping event without saturation enabled
  p_flag_needs_sat_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagSet |-> inSat);
  // R12: output holds between operations
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(outData));

endmodule

// File: rtl/sat_round_shifter.sv
module sat_round_shifter
  import vsr_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHIFT_W = 8,
  parameter int SIZE_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inData,
  input  logic [SHIFT_W-1:0] inShift,
  input  logic [SIZE_W-1:0]  inSize,
  input  logic [1:0]         inMode,
  input  logic               inRound,
  input  logic               inSat,
  input  logic               satClear,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic               satFlag
);

  ctrlStrobes_t strobes;
  logic         satEvent;
  shiftMode_e   modeSel;

  assign modeSel = shiftMode_e'(inMode);

  vsr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .satClear (satClear),
    .satEvent (satEvent),
    .strobes  (strobes),
    .outValid (outValid),
    .satFlag  (satFlag)
  );

  vsr_datapath #(
    .DATA_W  (DATA_W),
    .SHIFT_W (SHIFT_W),
    .SIZE_W  (SIZE_W)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inData   (inData),
    .inShift  (inShift),
    .inSize   (inSize),
    .inMode   (modeSel),
    .inRound  (inRound),
    .inSat    (inSat),
    .satEvent (satEvent),
    .outData  (outData)
  );

endmodule

// File: tb/sat_round_shifter_test.sv
`timescale 1ns/1ps
module sat_round_shifter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inData = '0;
  logic [7:0]  inShift = '0;
  logic [1:0]  inSize = '0;
  logic [1:0]  inMode = '0;
  logic        inRound = 1'b0;
  logic        inSat = 1'b0;
  logic        satClear = 1'b0;
  logic        outValid;
  logic [63:0] outData;
  logic        satFlag;

  int  nChecks = 0;
  int  nFails = 0;
  logic expFlag = 1'b0;
  logic [63:0] lastData = '0;
  bit  finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  sat_round_shifter uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inShift(inShift), .inSize(inSize), .inMode(inMode), .inRound(inRound),
    .inSat(inSat), .satClear(satClear), .outValid(outValid),
    .outData(outData), .satFlag(satFlag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: exact arithmetic on a wide signed value
  function automatic void refShift(input logic [63:0] d, input logic [7:0] sh,
      input logic [1:0] sz, input logic [1:0] md, input logic rnd, input logic sat,
      output logic [63:0] res, output logic ev, output string tag);
    int w; int sc; int n; logic neg;
    logic signed [129:0] v, r, p, maxS, minS, maxU;
    w    = 8 << sz;
    sc   = int'($signed(sh));
    maxU = (130'sd1 <<< w) - 130'sd1;
    maxS = (130'sd1 <<< (w - 1)) - 130'sd1;
    minS = -(130'sd1 <<< (w - 1));
    v    = $signed(130'(d)) & maxU;
    neg  = v[w-1];
    ev   = 1'b0;
    tag  = "R1";
    if (md == 2'd0 && neg) v = v - (130'sd1 <<< w);
    if (md == 2'd2 && sat && neg) begin
      r = '0; ev = 1'b1; tag = "R8";
    end else if (sc < 0) begin
      n = -sc;
      if (md == 2'd0 && n >= w) begin
        r = rnd ? 130'sd0 : (neg ? -130'sd1 : 130'sd0); tag = "R3";
      end else if (md != 2'd0 && n >= w + int'(rnd)) begin
        r = '0; tag = "R4";
      end else if (rnd) begin
        r = (v + (130'sd1 <<< (n - 1))) >>> n; tag = "R2";
      end else r = v >>> n;
    end else if (sc >= w) begin
      tag = "R7";
      if (v == 0 || !sat) r = '0;
      else begin
        ev = 1'b1;
        r = (md == 2'd0) ? (neg ? minS : maxS) : maxU;
      end
    end else begin
      p = v <<< sc;
      if ((md == 2'd0) ? (p > maxS || p < minS) : (p > maxU)) begin
        if (sat) begin
          ev = 1'b1;
          r = (md == 2'd0) ? (neg ? minS : maxS) : maxU;
          tag = (md == 2'd0) ? "R5" : "R6";
        end else begin
          r = p; tag = "R9";
        end
      end else r = p;
    end
    r = r & maxU;
    if (md == 2'd0 && r[w-1]) r = r | ~maxU;
    res = r[63:0];
  endfunction

  task automatic doOp(input logic [63:0] d, input logic [7:0] sh, input logic [1:0] sz,
      input logic [1:0] md, input logic rnd, input logic sat, input logic clr, input string forceTag);
    logic [63:0] expRes; logic ev; string tag;
    refShift(d, sh, sz, md, rnd, sat, expRes, ev, tag);
    if (forceTag != "") tag = forceTag;
    @(negedge clk);
    inValid = 1'b1; inData = d; inShift = sh; inSize = sz; inMode = md;
    inRound = rnd; inSat = sat; satClear = clr;
    expFlag = (clr ? 1'b0 : expFlag) | ev;
    @(negedge clk);
    inValid = 1'b0; satClear = 1'b0;
    check("R12", 64'(outValid), 64'd1);
    check(tag, outData, expRes);
    check("R10", 64'(satFlag), 64'(expFlag));
    lastData = expRes;
  endtask

  task automatic idleCheck();
    @(negedge clk);
    check("R12", 64'(outValid), 64'd0);
    check("R12", outData, lastData);
    check("R10", 64'(satFlag), 64'(expFlag));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", 64'(outValid), 64'd0);
    check("R12", outData, 64'd0);
    check("R10", 64'(satFlag), 64'd0);
    rstN = 1'b1;
    idleCheck();

    // directed corners
    doOp(64'h7f, 8'd1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, "R5");          // +max clamp
    doOp(64'h80, 8'd1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, "R5");          // -min clamp
    idleCheck();
    doOp(64'h1, 8'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, "R10");           // clear flag
    doOp(64'h5, 8'hff, 2'd1, 2'd1, 1'b1, 1'b0, 1'b0, "R2");           // 5>>1 rounds to 3
    doOp(64'hfffb, 8'hff, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, "R2");        // -5>>1 rounds to -2
    doOp(64'h80, 8'hf8, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R3");          // -8: sign fill
    doOp(64'h80, 8'hf8, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, "R3");          // rounded: zero
    doOp(64'h80, 8'hf8, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, "R4");          // unsigned -8 rnd: msb
    doOp(64'h80, 8'hf7, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, "R4");          // -9 rnd: zero
    doOp(64'h0, 8'd70, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0, "R7");           // zero stays zero
    doOp(64'h3, 8'd64, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, "R7");           // no sat: zero
    doOp(64'h3, 8'd64, 2'd3, 2'd1, 1'b0, 1'b1, 1'b0, "R6");           // all ones
    doOp(64'h1, 8'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, "R10");
    doOp(64'h9000, 8'd1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, "R9");         // wraps, no flag
    doOp(64'hff, 8'd0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b0, "R8");           // negative -> 0
    doOp(64'hff, 8'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b1, "R8");           // no sat: raw 0xff
    doOp(64'hdead_beef_0000_00f0, 8'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, "R11"); // upper bits ignored, sext
    doOp(64'hdead_beef_0000_00f0, 8'd0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, "R11"); // zext
    doOp(64'h8000_0000_0000_0001, 8'h80, 2'd3, 2'd0, 1'b1, 1'b1, 1'b0, "R3");
    doOp(64'h4000_0000_0000_0000, 8'd1, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0, "R5");
    doOp(64'h1, 8'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, "R10");           // clear
    doOp(64'h7f, 8'd1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, "R10");          // clear + event: set
    idleCheck();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] d; logic [7:0] sh; logic [1:0] sz; int w; int sel;
      sz  = 2'($urandom_range(0, 3));
      w   = 8 << sz;
      sel = int'($urandom_range(0, 9));
      if (sel < 2)      d = 64'($urandom_range(0, 3));
      else if (sel < 4) d = 64'h1 << $urandom_range(0, 63);
      else              d = {$urandom, $urandom};
      sel = int'($urandom_range(0, 9));
      if (sel < 7) sh = 8'($signed($urandom_range(0, 2 * w + 4)) - w - 2);
      else         sh = 8'($urandom);
      doOp(d, sh, sz, 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 15) == 0), "");
      if ($urandom_range(0, 7) == 0) idleCheck();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule